// File: doc/BRIEF.md
# Bridge Reset Sequencer

This block sequences reset for a bus bridge with a primary (upstream) side and a secondary (downstream) side. An active-low primary reset enters asynchronously. A two-stage synchronizer releases it on a clock edge. After release, the core is held inaccessible for a time that depends on the bus mode. Conventional mode holds for a short fixed count of bus clocks. PCI-X mode holds for a microsecond-scale interval so that an internal clock generator can settle. The mode strap is captured at the moment of release and then kept until the next primary reset.

The block also drives the active-low secondary bus reset. Two sources assert it: the primary reset, and a software-owned control bit that is written through a configuration write port. When both sources are gone, the sequencer waits for the external secondary clock-stable signal. It then counts a minimum stable-clock interval before it releases the secondary reset. If either source reasserts while the sequencer waits or counts, it returns to the held state and discards its progress.

The sequencer also produces override controls for the pads. One tri-states the primary pins while the core is inaccessible. One parks the secondary address/data and byte-enable lines low while the secondary reset is asserted. One tri-states the remaining secondary control lines during that same time.

Top module: `brg_rst_seq`

## Requirements
- R1: While prst_n is low, core_ready and sec_rst_n are 0 at once, with no clock edge needed, and sec_rst_ctl returns to its default of 0 at the next clock edge.
- R2: pri_hiz is 1 whenever core_ready is 0. sec_ad_park_low and sec_ctl_hiz are both 1 whenever sec_rst_n is 0. All three are 0 once both resets are released.
- R3: With pcix_strap = 0 (conventional mode), core_ready rises on the 10th rising clock edge after prst_n goes high: two synchronizer edges, one decode edge and CONV_HOLD = 7 hold clocks.
- R4: With pcix_strap = 1 (PCI-X mode), core_ready rises on rising edge 3 + CLK_MHZ*PLL_US (5003 with the defaults) after prst_n goes high.
- R5: With sec_clk_stable held high, sec_rst_n rises on rising edge 4 + CLK_MHZ*SETTLE_US (5004 with the defaults) after prst_n goes high.
- R6: When core_ready is 1, a configuration write (cfg_wr = 1) loads cfg_wdata into sec_rst_ctl at the clock edge. While sec_rst_ctl is 1, sec_rst_n is 0 from that edge on.
- R7: After both reset sources are gone, sec_rst_n stays 0 for as long as sec_clk_stable is 0, however long that is.
- R8: With sec_clk_stable already high, clearing sec_rst_ctl releases sec_rst_n on rising edge 3 + CLK_MHZ*SETTLE_US (5003) counted from the write edge. When sec_clk_stable rises after the sources are gone, sec_rst_n rises on edge 1 + CLK_MHZ*SETTLE_US (5001) counted from the rise.
- R9: If sec_rst_ctl is set again during the settle count, sec_rst_n goes back to 0 and the count restarts from zero, so a later clear again takes the full R8 time.
- R10: If sec_clk_stable drops during the settle count, the count is discarded. After it rises again, the full R8 interval applies.
- R11: bus_mode_pcix shows the strap value sampled at the primary reset release (1 = PCI-X, 0 = conventional). It does not follow later changes of pcix_strap.
- R12: Configuration writes that arrive while core_ready is 0 are ignored, and sec_rst_ctl keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bridge clock |
| prst_n | input | 1 | Primary reset, active low, asynchronous assertion |
| pcix_strap | input | 1 | Bus mode strap: 1 = PCI-X, 0 = conventional |
| cfg_wr | input | 1 | Configuration write strobe for the secondary-reset control bit |
| cfg_wdata | input | 1 | Value written into the control bit |
| sec_clk_stable | input | 1 | Secondary clock is stable |
| core_ready | output | 1 | Core accessible, internal reset finished |
| bus_mode_pcix | output | 1 | Latched bus mode |
| sec_rst_ctl | output | 1 | Current value of the secondary-reset control bit |
| sec_rst_n | output | 1 | Secondary bus reset, active low |
| pri_hiz | output | 1 | Force primary pins to tri-state |
| sec_ad_park_low | output | 1 | Drive secondary address/data and byte-enable lines low |
| sec_ctl_hiz | output | 1 | Force other secondary control lines to tri-state |

## Verification
A wrong sequencer state shows up as a change in a release edge. core_ready or sec_rst_n rises one or more edges early or late compared with the exact counts in R3, R4, R5 and R8, so every timed release is measured to the edge. A timer that is not cleared on an abort shows up as a second release that comes thousands of cycles early, within one settle interval of the abort. A broken asynchronous path shows up inside the same clock phase as the primary reset falling, before any edge. A gate on the control bit that is missing or too loose shows up in sec_rst_ctl a few cycles after a blocked write.

// File: rtl/brg_rst_pkg.sv
package brg_rst_pkg;

    typedef enum logic {
        MODE_CONV = 1'b0,
        MODE_PCIX = 1'b1
    } bus_mode_e;

    typedef enum logic [1:0] {
        CORE_RESET,
        CORE_CONV_WAIT,
        CORE_PLL_WAIT,
        CORE_READY
    } core_state_e;

    typedef enum logic [1:0] {
        SEC_HOLD,
        SEC_WAIT_CLK,
        SEC_SETTLE,
        SEC_LIVE
    } sec_state_e;

    typedef struct packed {
        logic pri_hiz;
        logic sec_ad_low;
        logic sec_ctl_hiz;
    } pin_ctl_t;

    function automatic int unsigned us_to_cycles(input int unsigned mhz, input int unsigned us);
        return mhz * us;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/brg_rst_sync.sv
module brg_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_o
);
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) shift_q <= '0;
        else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end

    assign rst_o = ~shift_q[STAGES-1];

    // R1
    rel_after_input_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_o) |-> $past(arst_n));

endmodule

// File: rtl/brg_core_seq.sv
module brg_core_seq
    import brg_rst_pkg::*;
#(
    parameter int unsigned CONV_HOLD = 7,
    parameter int unsigned PLL_CYC   = 5000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      mode_in,
    output logic      ready,
    output bus_mode_e mode_o
);
    localparam int CW = cnt_bits(CONV_HOLD);
    localparam int PW = cnt_bits(PLL_CYC);

    core_state_e    st_q;
    logic [CW-1:0]  conv_q;
    logic [PW-1:0]  pll_q;
    bus_mode_e      mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CORE_RESET;
            conv_q <= '0;
            pll_q  <= '0;
            mode_q <= bus_mode_e'(mode_in);
        end else begin
            unique case (st_q)
                CORE_RESET:
                    st_q <= (mode_q == MODE_PCIX) ? CORE_PLL_WAIT : CORE_CONV_WAIT;
                CORE_CONV_WAIT:
                    if (conv_q == CW'(CONV_HOLD - 1)) st_q <= CORE_READY;
                    else                              conv_q <= conv_q + 1'b1;
                CORE_PLL_WAIT:
                    if (pll_q == PW'(PLL_CYC - 1)) st_q <= CORE_READY;
                    else                           pll_q <= pll_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign ready  = (st_q == CORE_READY) && !rst;
    assign mode_o = mode_q;

    // R11
    mode_held_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mode_q));

    // R3
    conv_only_in_conv_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == CORE_CONV_WAIT) |-> (mode_q == MODE_CONV));

    // R4
    ready_from_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == CORE_READY && $past(st_q) != CORE_READY) |->
            ($past(st_q) == CORE_CONV_WAIT || $past(st_q) == CORE_PLL_WAIT));

endmodule

// File: rtl/brg_sec_seq.sv
module brg_sec_seq
    import brg_rst_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic clk_stable,
    output logic rst_n_o
);
    localparam int TW = cnt_bits(SETTLE_CYC);

    sec_state_e    st_q;
    logic [TW-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (hold) begin
            st_q  <= SEC_HOLD;
            tmr_q <= '0;
        end else begin
            unique case (st_q)
                SEC_HOLD:
                    st_q <= SEC_WAIT_CLK;
                SEC_WAIT_CLK: begin
                    tmr_q <= '0;
                    if (clk_stable) st_q <= SEC_SETTLE;
                end
                SEC_SETTLE:
                    if (!clk_stable) begin
                        st_q  <= SEC_WAIT_CLK;
                        tmr_q <= '0;
                    end else if (tmr_q == TW'(SETTLE_CYC - 1)) begin
                        st_q <= SEC_LIVE;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                default: ;
            endcase
        end
    end

    assign rst_n_o = (st_q == SEC_LIVE) && !hold;

    // R8
    live_from_settle_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEC_LIVE && $past(st_q) != SEC_LIVE) |->
            ($past(st_q) == SEC_SETTLE && $past(clk_stable)));

    // R10
    drop_restarts_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEC_SETTLE && !clk_stable && !hold) |=> (st_q == SEC_WAIT_CLK && tmr_q == '0));

    // R9
    hold_returns_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> (st_q == SEC_HOLD && !rst_n_o));

endmodule

// File: rtl/brg_ctl_bit.sv
module brg_ctl_bit (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic wr,
    input  logic wdata,
    output logic bit_o
);
    logic bit_q;

    always_ff @(posedge clk) begin
        if (rst)              bit_q <= 1'b0;
        else if (enable && wr) bit_q <= wdata;
    end

    assign bit_o = bit_q;

    // R12
    blocked_write_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(bit_q));

endmodule

// File: rtl/brg_rst_seq.sv
module brg_rst_seq
    import brg_rst_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 50,
    parameter int unsigned SETTLE_US = 100,
    parameter int unsigned PLL_US    = 100,
    parameter int unsigned CONV_HOLD = 7,
    parameter int          SYNC_STG  = 2
) (
    input  logic clk,
    input  logic prst_n,
    input  logic pcix_strap,
    input  logic cfg_wr,
    input  logic cfg_wdata,
    input  logic sec_clk_stable,
    output logic core_ready,
    output logic bus_mode_pcix,
    output logic sec_rst_ctl,
    output logic sec_rst_n,
    output logic pri_hiz,
    output logic sec_ad_park_low,
    output logic sec_ctl_hiz
);
    localparam int unsigned SETTLE_CYC = us_to_cycles(CLK_MHZ, SETTLE_US);
    localparam int unsigned PLL_CYC    = us_to_cycles(CLK_MHZ, PLL_US);

    logic      pri_rst;
    logic      ready;
    bus_mode_e mode;
    logic      ctl_bit;
    logic      sec_hold;
    logic      sec_rel_n;
    pin_ctl_t  pins;

    brg_rst_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .arst_n (prst_n),
        .rst_o  (pri_rst)
    );

    brg_core_seq #(.CONV_HOLD(CONV_HOLD), .PLL_CYC(PLL_CYC)) u_core (
        .clk     (clk),
        .rst     (pri_rst),
        .mode_in (pcix_strap),
        .ready   (ready),
        .mode_o  (mode)
    );

    brg_ctl_bit u_ctl (
        .clk    (clk),
        .rst    (pri_rst),
        .enable (ready),
        .wr     (cfg_wr),
        .wdata  (cfg_wdata),
        .bit_o  (ctl_bit)
    );

    assign sec_hold = pri_rst | ctl_bit;

    brg_sec_seq #(.SETTLE_CYC(SETTLE_CYC)) u_sec (
        .clk        (clk),
        .rst        (pri_rst),
        .hold       (sec_hold),
        .clk_stable (sec_clk_stable),
        .rst_n_o    (sec_rel_n)
    );

    always_comb begin
        pins.pri_hiz     = !ready;
        pins.sec_ad_low  = !sec_rel_n;
        pins.sec_ctl_hiz = !sec_rel_n;
    end

    assign core_ready      = ready;
    assign bus_mode_pcix   = (mode == MODE_PCIX);
    assign sec_rst_ctl     = ctl_bit;
    assign sec_rst_n       = sec_rel_n;
    assign pri_hiz         = pins.pri_hiz;
    assign sec_ad_park_low = pins.sec_ad_low;
    assign sec_ctl_hiz     = pins.sec_ctl_hiz;

    // R6
    bit_forces_sec_chk: assert property (@(posedge clk) disable iff (pri_rst)
        ctl_bit |-> !sec_rst_n);

    // R2
    park_with_reset_chk: assert property (@(posedge clk) disable iff (pri_rst)
        !sec_rst_n |-> (sec_ad_park_low && sec_ctl_hiz));

    // R5
    sec_after_core_chk: assert property (@(posedge clk) disable iff (pri_rst)
        $rose(sec_rst_n) |-> !$past(pri_rst));

endmodule

// File: tb/sim_brg_rst_seq.sv
module sim_brg_rst_seq;
    localparam int SETTLE = 50 * 100;
    localparam int PLL    = 50 * 100;

    logic clk = 1'b0;
    logic prst_n, pcix_strap, cfg_wr, cfg_wdata, sec_clk_stable;
    logic core_ready, bus_mode_pcix, sec_rst_ctl, sec_rst_n;
    logic pri_hiz, sec_ad_park_low, sec_ctl_hiz;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    brg_rst_seq u0 (
        .clk(clk), .prst_n(prst_n), .pcix_strap(pcix_strap), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .sec_clk_stable(sec_clk_stable),
        .core_ready(core_ready), .bus_mode_pcix(bus_mode_pcix),
        .sec_rst_ctl(sec_rst_ctl), .sec_rst_n(sec_rst_n), .pri_hiz(pri_hiz),
        .sec_ad_park_low(sec_ad_park_low), .sec_ctl_hiz(sec_ctl_hiz)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_write(input logic v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    // release prst_n and count edges to core_ready and to sec_rst_n
    task automatic release_timed(output int core_n, output int sec_n);
        core_n = 0; sec_n = 0;
        @(negedge clk); prst_n = 1'b1;
        for (int n = 1; n <= 20000; n++) begin
            @(posedge clk); #1;
            if (core_ready && core_n == 0) core_n = n;
            if (sec_rst_n && sec_n == 0) sec_n = n;
            if (core_n != 0 && sec_n != 0) break;
        end
    endtask

    // count edges until sec_rst_n rises; edge 1 is the first after the call
    task automatic count_sec(input bit drop_wr, output int n_o);
        n_o = 0;
        for (int n = 1; n <= 20000; n++) begin
            @(posedge clk); #1;
            if (drop_wr && n == 1) cfg_wr = 1'b0;
            if (sec_rst_n) begin n_o = n; break; end
        end
    endtask

    task automatic t_reset_state;
        chk("R1 core_ready in reset", core_ready, 0);
        chk("R1 sec_rst_n in reset", sec_rst_n, 0);
        chk("R1 sec_rst_ctl default", sec_rst_ctl, 0);
        chk("R2 pri_hiz in reset", pri_hiz, 1);
        chk("R2 sec_ad_park_low in reset", sec_ad_park_low, 1);
        chk("R2 sec_ctl_hiz in reset", sec_ctl_hiz, 1);
    endtask

    task automatic t_conv_release;
        int c, s;
        pcix_strap = 1'b0; sec_clk_stable = 1'b1;
        release_timed(c, s);
        chk("R3 conventional core_ready edge", c, 10);
        chk("R5 sec_rst_n release edge", s, SETTLE + 4);
        chk("R11 mode conventional", bus_mode_pcix, 0);
        chk("R2 pri_hiz released", pri_hiz, 0);
        chk("R2 sec_ad_park_low released", sec_ad_park_low, 0);
        chk("R2 sec_ctl_hiz released", sec_ctl_hiz, 0);
    endtask

    task automatic t_bit_set;
        pulse_write(1'b1);
        chk("R6 control bit set", sec_rst_ctl, 1);
        chk("R6 sec_rst_n forced low", sec_rst_n, 0);
        chk("R2 park low with bit", sec_ad_park_low, 1);
        chk("R2 pri_hiz unaffected by bit", pri_hiz, 0);
    endtask

    task automatic t_bit_clear_timed;
        int n;
        sec_clk_stable = 1'b1;
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 1'b0;
        count_sec(1'b1, n);
        chk("R8 release edge after clear", n, SETTLE + 3);
        chk("R6 control bit cleared", sec_rst_ctl, 0);
    endtask

    task automatic t_clear_waits_clock;
        int n;
        pulse_write(1'b1);
        sec_clk_stable = 1'b0;
        pulse_write(1'b0);
        repeat (6000) @(negedge clk);
        chk("R7 held without stable clock", sec_rst_n, 0);
        sec_clk_stable = 1'b1;
        count_sec(1'b0, n);
        chk("R8 release edge after stable rise", n, SETTLE + 1);
    endtask

    task automatic t_abort_by_bit;
        int n;
        pulse_write(1'b1);
        pulse_write(1'b0);
        repeat (1000) @(negedge clk);
        chk("R9 still counting", sec_rst_n, 0);
        pulse_write(1'b1);
        chk("R9 reassert holds reset", sec_rst_n, 0);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 1'b0;
        count_sec(1'b1, n);
        chk("R9 full interval after abort", n, SETTLE + 3);
    endtask

    task automatic t_stable_drop;
        int n;
        pulse_write(1'b1);
        pulse_write(1'b0);
        repeat (1000) @(negedge clk);
        sec_clk_stable = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 held while clock unstable", sec_rst_n, 0);
        sec_clk_stable = 1'b1;
        count_sec(1'b0, n);
        chk("R10 full interval after drop", n, SETTLE + 1);
    endtask

    task automatic t_async_reset;
        pulse_write(1'b1);
        chk("R6 bit set before reset", sec_rst_ctl, 1);
        pulse_write(1'b0);
        repeat (SETTLE + 10) @(negedge clk);
        chk("R8 live before async reset", sec_rst_n, 1);
        pulse_write(1'b1);
        @(posedge clk); #5;
        prst_n = 1'b0;
        #1;
        chk("R1 core_ready drops without edge", core_ready, 0);
        chk("R1 sec_rst_n low without edge", sec_rst_n, 0);
        chk("R2 pri_hiz without edge", pri_hiz, 1);
        repeat (3) @(negedge clk);
        chk("R1 control bit back to default", sec_rst_ctl, 0);
    endtask

    task automatic t_pcix_release;
        int c, s;
        pcix_strap = 1'b1; sec_clk_stable = 1'b1;
        release_timed(c, s);
        chk("R4 PCI-X core_ready edge", c, PLL + 3);
        chk("R5 sec_rst_n release edge PCI-X", s, SETTLE + 4);
        chk("R11 mode PCI-X latched", bus_mode_pcix, 1);
        pcix_strap = 1'b0;
        repeat (5) @(negedge clk);
        chk("R11 mode ignores strap change", bus_mode_pcix, 1);
    endtask

    task automatic t_blocked_write;
        @(negedge clk); prst_n = 1'b0;
        repeat (3) @(negedge clk);
        pcix_strap = 1'b0; sec_clk_stable = 1'b0;
        prst_n = 1'b1;
        cfg_wr = 1'b1; cfg_wdata = 1'b1;
        repeat (4) @(negedge clk);
        cfg_wr = 1'b0;
        repeat (20) @(negedge clk);
        chk("R12 core ready after hold", core_ready, 1);
        chk("R12 write during hold ignored", sec_rst_ctl, 0);
        chk("R7 no stable clock keeps reset", sec_rst_n, 0);
    endtask

    initial begin
        prst_n = 1'b0; pcix_strap = 1'b0; cfg_wr = 1'b0; cfg_wdata = 1'b0;
        sec_clk_stable = 1'b1;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_conv_release();
        t_bit_set();
        t_bit_clear_timed();
        t_clear_waits_clock();
        t_abort_by_bit();
        t_stable_drop();
        t_async_reset();
        t_pcix_release();
        t_blocked_write();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule